// File: doc/BRIEF.md
# Dual-Ring Direction Selector

This block makes the per-cell routing decision for one node of a fabric built from two rings that carry traffic in opposite directions. A cell arrives with the index of the node that is sending it, its destination index and a snapshot of fabric health. Health is one flag per clockwise link, one per counter-clockwise link and one per node. The block answers with the ring to launch the cell on and the number of hops the cell will travel.

By default the cell takes the shorter way round. If that way crosses a dead link, a dead intermediate node or a dead destination, the cell is sent the other way. When both ways are blocked the cell is marked unroutable. A cell addressed to its own node is delivered locally and never enters a ring. A single fault anywhere therefore leaves every healthy destination reachable.

Requests and decisions flow through valid/ready handshakes with one register stage between them. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the decision stays frozen and no new request is taken. Health flags are sampled only at acceptance.

Top module: `ring_dir_sel`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: A request accepted on a clock edge gives its decision at the outputs, with `out_valid` high, right after that same edge.
- R3: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_dir`, `out_hops` and `out_unroutable` hold their values.
- R4: When the destination equals the source, `out_dir` is 2'b00 (local) and `out_hops` is 0, whatever the health flags say.
- R5: Clockwise distance is (dst - src) mod NODES and counter-clockwise distance is (src - dst) mod NODES. With no blocking fault the shorter direction is chosen, with clockwise winning ties. `out_dir` is 2'b01 for clockwise and 2'b10 for counter-clockwise, and `out_hops` carries that distance. With all flags healthy the hop count never exceeds NODES/2.
- R6: If the preferred path is blocked and the other path is clear, the other direction is chosen and `out_hops` is that direction's distance.
- R7: If both paths are blocked, `out_unroutable` is 1, `out_dir` is 2'b11 and `out_hops` is 0. A dead destination node blocks both paths.
- R8: Health flag positions are as follows. Bit k of `cw_link_ok` is the link from node k to node (k+1) mod NODES. Bit k of `ccw_link_ok` is the link from node k to node (k-1) mod NODES. Bit k of `node_ok` is node k. A path is blocked only by a flag it uses: its own-direction links from the source to the node before the destination, the nodes it passes through, and the destination. Other flags are ignored.
- R9: With at most one flag low, every destination whose node flag is high is routable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_src | input | $clog2(NODES) | Index of the sending node |
| in_dst | input | $clog2(NODES) | Index of the destination node |
| cw_link_ok | input | NODES | Clockwise link health, bit k = link k to k+1 |
| ccw_link_ok | input | NODES | Counter-clockwise link health, bit k = link k to k-1 |
| node_ok | input | NODES | Node health, bit k = node k |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Consumer takes the decision this cycle |
| out_dir | output | 2 | 00 local, 01 clockwise, 10 counter-clockwise, 11 none |
| out_hops | output | $clog2(NODES) | Hops on the chosen ring |
| out_unroutable | output | 1 | Both paths blocked |

## Verification
The bench goes after the corners where the wrap and fault arithmetic tend to slip. These include the exact tie at half the ring, which a design with an inverted compare would send counter-clockwise. They include a source-to-destination span that crosses index zero, where a modulus mistake gives a hop count of NODES minus the true value. Faults are placed on a link or node just inside and just outside the path, so an off-by-one path mask would either miss the block or reroute a healthy cell. A dead destination has to make the cell unroutable and not route it the long way. A sweep of every single fault for every source and destination pair would expose a design that fails to reverse. A stall test catches a design that drops or overwrites a held decision.

// File: rtl/ring_sel_pkg.sv
package ring_sel_pkg;
  typedef enum logic [1:0] {
    DIR_LOCAL = 2'b00,
    DIR_CW    = 2'b01,
    DIR_CCW   = 2'b10,
    DIR_NONE  = 2'b11
  } ring_dir_e;
endpackage

// File: rtl/ring_hop_dist.sv
// Modular hop distance in both ring directions.
module ring_hop_dist #(
  parameter int NODES = 8,
  localparam int IDW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic [IDW-1:0] src,
  input  logic [IDW-1:0] dst,
  output logic [IDW-1:0] dist_cw,
  output logic [IDW-1:0] dist_ccw
);
  // NODES folded into IDW bits; zero when NODES is a power of two,
  // which keeps the wrap correct because every result is below NODES.
  localparam logic [IDW-1:0] NMOD = IDW'(NODES);

  always_comb begin
    if (dst >= src) dist_cw = dst - src;
    else            dist_cw = dst - src + NMOD;
    if (src >= dst) dist_ccw = src - dst;
    else            dist_ccw = src - dst + NMOD;
  end
endmodule

// File: rtl/ring_path_ok.sv
// Checks that every link and node on one direction's path is healthy.
// Step j (1..hops) leaves node pos[j-1] over its own-direction link
// and lands on node pos[j].
module ring_path_ok #(
  parameter int NODES = 8,
  parameter bit CLOCKWISE = 1'b1,
  localparam int IDW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic [IDW-1:0]   src,
  input  logic [IDW-1:0]   hops,
  input  logic [NODES-1:0] link_ok,
  input  logic [NODES-1:0] node_ok,
  output logic             clear
);
  logic [IDW-1:0]   pos [NODES];
  logic [NODES-1:0] step_ok;

  assign pos[0]     = src;
  assign step_ok[0] = 1'b1;

  for (genvar j = 1; j < NODES; j++) begin : g_step
    localparam logic [IDW-1:0] STEP = IDW'(j);
    localparam logic [IDW-1:0] BACK = IDW'(NODES - j);
    if (CLOCKWISE) begin : g_cw
      assign pos[j] = (src >= BACK) ? src - BACK : src + STEP;
    end else begin : g_ccw
      assign pos[j] = (src >= STEP) ? src - STEP : src + BACK;
    end
    assign step_ok[j] = (STEP > hops) ||
                        (link_ok[pos[j-1]] && node_ok[pos[j]]);
  end

  assign clear = &step_ok;
endmodule

// File: rtl/ring_route_pick.sv
// Chooses the ring from distances and path health.
module ring_route_pick
  import ring_sel_pkg::*;
#(
  parameter int NODES = 8,
  localparam int IDW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic           is_local,
  input  logic [IDW-1:0] dist_cw,
  input  logic [IDW-1:0] dist_ccw,
  input  logic           cw_clear,
  input  logic           ccw_clear,
  output ring_dir_e      dir,
  output logic [IDW-1:0] hops,
  output logic           unroutable
);
  logic prefer_cw;
  assign prefer_cw = (dist_cw <= dist_ccw);

  always_comb begin
    dir        = DIR_NONE;
    hops       = '0;
    unroutable = 1'b0;
    if (is_local) begin
      dir = DIR_LOCAL;
    end else if (prefer_cw && cw_clear) begin
      dir  = DIR_CW;
      hops = dist_cw;
    end else if (!prefer_cw && ccw_clear) begin
      dir  = DIR_CCW;
      hops = dist_ccw;
    end else if (cw_clear) begin
      dir  = DIR_CW;
      hops = dist_cw;
    end else if (ccw_clear) begin
      dir  = DIR_CCW;
      hops = dist_ccw;
    end else begin
      unroutable = 1'b1;
    end
  end
endmodule

// File: rtl/ring_dir_sel.sv
module ring_dir_sel
  import ring_sel_pkg::*;
#(
  parameter int NODES = 8,
  localparam int IDW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDW-1:0]   in_src,
  input  logic [IDW-1:0]   in_dst,
  input  logic [NODES-1:0] cw_link_ok,
  input  logic [NODES-1:0] ccw_link_ok,
  input  logic [NODES-1:0] node_ok,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_dir,
  output logic [IDW-1:0]   out_hops,
  output logic             out_unroutable
);
  logic [IDW-1:0] dist_cw, dist_ccw;
  logic           cw_clear, ccw_clear;
  ring_dir_e      nxt_dir;
  logic [IDW-1:0] nxt_hops;
  logic           nxt_unr;
  logic           take;

  ring_hop_dist #(.NODES(NODES)) u_dist (
    .src      (in_src),
    .dst      (in_dst),
    .dist_cw  (dist_cw),
    .dist_ccw (dist_ccw)
  );

  ring_path_ok #(.NODES(NODES), .CLOCKWISE(1'b1)) u_cw_path (
    .src     (in_src),
    .hops    (dist_cw),
    .link_ok (cw_link_ok),
    .node_ok (node_ok),
    .clear   (cw_clear)
  );

  ring_path_ok #(.NODES(NODES), .CLOCKWISE(1'b0)) u_ccw_path (
    .src     (in_src),
    .hops    (dist_ccw),
    .link_ok (ccw_link_ok),
    .node_ok (node_ok),
    .clear   (ccw_clear)
  );

  ring_route_pick #(.NODES(NODES)) u_pick (
    .is_local   (in_src == in_dst),
    .dist_cw    (dist_cw),
    .dist_ccw   (dist_ccw),
    .cw_clear   (cw_clear),
    .ccw_clear  (ccw_clear),
    .dir        (nxt_dir),
    .hops       (nxt_hops),
    .unroutable (nxt_unr)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_dir        <= DIR_NONE;
      out_hops       <= '0;
      out_unroutable <= 1'b0;
    end else begin
      if (take) begin
        out_valid      <= 1'b1;
        out_dir        <= nxt_dir;
        out_hops       <= nxt_hops;
        out_unroutable <= nxt_unr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ring_dir_sel_chk.sv
module ring_dir_sel_chk #(
  parameter int NODES = 8,
  localparam int IDW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IDW-1:0]   in_src,
  input logic [IDW-1:0]   in_dst,
  input logic [NODES-1:0] cw_link_ok,
  input logic [NODES-1:0] ccw_link_ok,
  input logic [NODES-1:0] node_ok,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_dir,
  input logic [IDW-1:0]   out_hops,
  input logic             out_unroutable
);
  logic accept;
  assign accept = in_valid && in_ready;

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dir) &&
                                $stable(out_hops) && $stable(out_unroutable));

  p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_src == in_dst) |=> out_dir == 2'b00 && out_hops == '0);

  p_half_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (&cw_link_ok) && (&ccw_link_ok) && (&node_ok)
      |=> !out_unroutable && (int'(out_hops) <= NODES / 2));

  p_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unroutable |-> out_dir == 2'b11 && out_hops == '0);

  p_single_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && node_ok[in_dst] &&
    ($countones({~cw_link_ok, ~ccw_link_ok, ~node_ok}) <= 1)
      |=> !out_unroutable);
endmodule

bind ring_dir_sel ring_dir_sel_chk #(.NODES(NODES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_src         (in_src),
  .in_dst         (in_dst),
  .cw_link_ok     (cw_link_ok),
  .ccw_link_ok    (ccw_link_ok),
  .node_ok        (node_ok),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_dir        (out_dir),
  .out_hops       (out_hops),
  .out_unroutable (out_unroutable)
);

// File: tb/sim_ring_dir_sel.sv
module sim_ring_dir_sel;
  localparam int N  = 8;
  localparam int IW = 3;
  // {src, dst, cw, ccw, node, dir, hops, unroutable}
  localparam int VW = 3 + 3 + 8 + 8 + 8 + 2 + 3 + 1;
  localparam int NV = 14;
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd2, 3'd2, 8'hFF, 8'hFF, 8'hFF, 2'b00, 3'd0, 1'b0}, // R4 local
    {3'd0, 3'd3, 8'hFF, 8'hFF, 8'hFF, 2'b01, 3'd3, 1'b0}, // R5 cw short
    {3'd0, 3'd5, 8'hFF, 8'hFF, 8'hFF, 2'b10, 3'd3, 1'b0}, // R5 ccw short
    {3'd1, 3'd5, 8'hFF, 8'hFF, 8'hFF, 2'b01, 3'd4, 1'b0}, // R5 tie
    {3'd6, 3'd1, 8'hFF, 8'hFF, 8'hFF, 2'b01, 3'd3, 1'b0}, // R5 wrap
    {3'd0, 3'd3, 8'hFD, 8'hFF, 8'hFF, 2'b10, 3'd5, 1'b0}, // R6 link
    {3'd0, 3'd3, 8'hFF, 8'hFF, 8'hFB, 2'b10, 3'd5, 1'b0}, // R6 node
    {3'd0, 3'd3, 8'hFF, 8'hFF, 8'hF7, 2'b11, 3'd0, 1'b1}, // R7 dead dst
    {3'd0, 3'd3, 8'hFD, 8'hDF, 8'hFF, 2'b11, 3'd0, 1'b1}, // R7 both
    {3'd0, 3'd3, 8'hF7, 8'hFF, 8'hFF, 2'b01, 3'd3, 1'b0}, // R8 link past dst
    {3'd0, 3'd3, 8'hFF, 8'hFB, 8'hFE, 2'b01, 3'd3, 1'b0}, // R8 off-path
    {3'd4, 3'd1, 8'hFF, 8'hFF, 8'hFE, 2'b10, 3'd3, 1'b0}, // R8 beyond dst
    {3'd7, 3'd0, 8'h7F, 8'hFF, 8'hFF, 2'b10, 3'd7, 1'b0}, // R6 long way
    {3'd3, 3'd3, 8'h00, 8'h00, 8'h00, 2'b00, 3'd0, 1'b0}  // R4 all dead
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [IW-1:0] in_src = '0;
  logic [IW-1:0] in_dst = '0;
  logic [N-1:0]  cw_link_ok = '1;
  logic [N-1:0]  ccw_link_ok = '1;
  logic [N-1:0]  node_ok = '1;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    out_dir;
  logic [IW-1:0] out_hops;
  logic          out_unroutable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ring_dir_sel #(.NODES(N)) u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model written from the requirements.
  function automatic logic [5:0] model(input int s, input int d,
      input logic [N-1:0] cw, input logic [N-1:0] ccw, input logic [N-1:0] nd);
    int hc, ha;
    bit okc, oka;
    if (s == d) return {2'b00, 3'd0, 1'b0};
    hc = (d - s + N) % N;
    ha = (s - d + N) % N;
    okc = 1; oka = 1;
    for (int k = 1; k <= hc; k++)
      okc &= cw[(s + k - 1) % N] & nd[(s + k) % N];
    for (int k = 1; k <= ha; k++)
      oka &= ccw[(s - k + 1 + N) % N] & nd[(s - k + N) % N];
    if (hc <= ha && okc) return {2'b01, 3'(hc), 1'b0};
    if (hc >  ha && oka) return {2'b10, 3'(ha), 1'b0};
    if (okc) return {2'b01, 3'(hc), 1'b0};
    if (oka) return {2'b10, 3'(ha), 1'b0};
    return {2'b11, 3'd0, 1'b1};
  endfunction

  // Drive at negedge, accept at posedge, sample at following negedge.
  task automatic send(input int s, input int d, input logic [N-1:0] cw,
      input logic [N-1:0] ccw, input logic [N-1:0] nd);
    in_valid = 1'b1; in_src = IW'(s); in_dst = IW'(d);
    cw_link_ok = cw; ccw_link_ok = ccw; node_ok = nd;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready after reset", int'(in_ready), 1);

    foreach (VEC[i]) begin
      logic [VW-1:0] v;
      v = VEC[i];
      send(int'(v[35:33]), int'(v[32:30]), v[29:22], v[21:14], v[13:6]);
      check("R2 valid after accept", int'(out_valid), 1);
      check("R4-R8 table dir", int'(out_dir), int'(v[5:4]));
      check("R5 R6 table hops", int'(out_hops), int'(v[3:1]));
      check("R7 table unroutable", int'(out_unroutable), int'(v[0]));
    end
    @(negedge clk);
    check("R2 valid drops when drained", int'(out_valid), 0);

    // R3 back-pressure
    out_ready = 1'b0;
    send(0, 5, '1, '1, '1);
    send(0, 3, '1, '1, '1);  // offered while stalled, must not be taken
    repeat (2) @(negedge clk);
    check("R3 held valid", int'(out_valid), 1);
    check("R3 in_ready low", int'(in_ready), 0);
    check("R3 held dir", int'(out_dir), 2);
    check("R3 held hops", int'(out_hops), 3);
    out_ready = 1'b1;
    @(negedge clk);
    check("R3 drained", int'(out_valid), 0);

    // R9 with R6/R7/R8 model: every single fault, every pair
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++)
        for (int f = 0; f < 3 * N; f++) begin
          logic [N-1:0] cw, ccw, nd;
          logic [5:0] exp;
          cw = '1; ccw = '1; nd = '1;
          if (f < N) cw[f] = 1'b0;
          else if (f < 2 * N) ccw[f - N] = 1'b0;
          else nd[f - 2 * N] = 1'b0;
          exp = model(s, d, cw, ccw, nd);
          send(s, d, cw, ccw, nd);
          check("R6 R8 sweep dir", int'(out_dir), int'(exp[5:4]));
          check("R6 R8 sweep hops", int'(out_hops), int'(exp[3:1]));
          if (nd[d]) check("R9 single fault routable", int'(out_unroutable), 0);
          else       check("R7 dead destination", int'(out_unroutable), int'(s != d));
        end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule